// File: doc/BRIEF.md
# Read-to-Set Hardware Lock Register Block

This block is a small slave register set on a 16-bit local bus that two processor cores share. Its main job is a one-bit hardware lock that sets as a side effect of being read. A read that finds the bit clear returns 0 and sets the bit when that bus cycle ends. Every later read returns 1 until software writes an all-zero word to clear it. This gives a test-and-set primitive on a bus that has no locked cycles.

The lock guards a separate 16-bit core semaphore register. Software may only change that register while it holds the lock, but the hardware does not enforce this. The same decode also serves a read-only backplane status register with three input bits and a read/write backplane command register that drives two backplane outputs.

On the bus, register bit n is carried on data line 15-n. Reads return data combinationally while the read strobe is high. Writes take effect at each clock edge where chip select and the write strobe are both high.

Top module: `hwlock_regs`

## Requirements
- R1: A synchronous active-high reset clears the lock bit, the core semaphore register and the command outputs.
- R2: A selected read of the lock register (offset 0x70) while the bit is 0 returns 0x0000 on every clock of its strobe. The bit becomes 1 on the clock edge where that read strobe, chip select or address stops selecting the lock. Exactly one set happens per read cycle.
- R3: A selected read of the lock register while the bit is 1 returns 0x8000 (register bit 0 on data line 15), and the bit stays 1.
- R4: A selected write of 0x0000 to the lock register clears the bit. If that write falls on the same edge as the end of a lock read cycle, the clear wins.
- R5: A selected write of any nonzero value to the lock register leaves the lock bit unchanged.
- R6: The core semaphore register at offset 0x74 is 16 bits, readable and writable whatever the lock state. Register bit n sits on data line 15-n, so a written word reads back unchanged.
- R7: The status register at offset 0x3C returns the three status inputs in bits 0..2 on data lines 15..13, with all other lines 0. Writes to it change nothing.
- R8: The command register at offset 0x40 takes bits 0 and 1 from data lines 15 and 14. It drives them on the command outputs and reads them back on the same lines, with the other lines 0.
- R9: Read data is 0x0000 when chip select or the read strobe is low, or when the offset is not one of the four decoded offsets. Such reads have no side effect.
- R10: A write with chip select low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Chip select for this register block |
| busAddr | input | 8 | Byte offset |
| busRd | input | 1 | Read strobe, may be held for several clocks |
| busWr | input | 1 | Write strobe |
| busWdata | input | 16 | Write data, register bit n on line 15-n |
| busRdata | output | 16 | Read data, register bit n on line 15-n |
| bpStatus | input | 3 | Backplane status inputs |
| bpCmd | output | 2 | Backplane command outputs |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, a 16-bit data bus, three status bits and two command bits. With an 8-bit offset, the bench can read every one of the 256 offsets and confirm that undecoded ones return zero and leave the lock alone. With 16 data lines, the reversed bit mapping of the lock, status and command fields can be checked line by line. A multi-clock lock read, and a clear that coincides with the end of a lock read, exercise the test-and-set timing at its edges.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

  // Strobes passed from the decode/control logic to the register datapath.
  typedef struct packed {
    logic lockSet;   // end of a lock read cycle
    logic lockClr;   // zero-word write to the lock
    logic coreWr;
    logic cmdWr;
    logic rdLock;
    logic rdCore;
    logic rdStat;
    logic rdCmd;
  } hwlockStrobes_t;

endpackage

// File: rtl/hwlock_ctrl.sv
module hwlock_ctrl
  import hwlock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] LOCK_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] CORE_OFS = 8'h74,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h3C,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output hwlockStrobes_t    strobes
);

  logic hitLock, hitCore, hitStat, hitCmd;
  logic rdEn, wrEn;
  logic lockRdNow;
  logic lockRdPrevQ;

  assign hitLock = (busAddr == LOCK_OFS);
  assign hitCore = (busAddr == CORE_OFS);
  assign hitStat = (busAddr == STAT_OFS);
  assign hitCmd  = (busAddr == CMD_OFS);

  assign rdEn = busSel & busRd;
  assign wrEn = busSel & busWr;
  assign lockRdNow = rdEn & hitLock;

  // Remember whether a lock read was in progress on the previous clock.
  always_ff @(posedge clk) begin
    if (rst) lockRdPrevQ <= 1'b0;
    else     lockRdPrevQ <= lockRdNow;
  end

  always_comb begin
    strobes.lockSet = lockRdPrevQ & ~lockRdNow;
    strobes.lockClr = wrEn & hitLock & (busWdata == '0);
    strobes.coreWr  = wrEn & hitCore;
    strobes.cmdWr   = wrEn & hitCmd;
    strobes.rdLock  = rdEn & hitLock;
    strobes.rdCore  = rdEn & hitCore;
    strobes.rdStat  = rdEn & hitStat;
    strobes.rdCmd   = rdEn & hitCmd;
  end

  // R2: a set can never fire on two consecutive clocks.
  a_r2_single_set: assert property (@(posedge clk) disable iff (rst)
    strobes.lockSet |=> !strobes.lockSet);

  // R10 / R9: without chip select no write or read strobe is raised.
  a_r10_no_sel_no_access: assert property (@(posedge clk) disable iff (rst)
    !busSel |-> !(strobes.lockClr || strobes.coreWr || strobes.cmdWr ||
                  strobes.rdLock || strobes.rdCore || strobes.rdStat || strobes.rdCmd));

endmodule

// File: rtl/hwlock_dp.sv
module hwlock_dp
  import hwlock_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 3,
  parameter int CMD_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  hwlockStrobes_t    strobes,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [STAT_W-1:0] bpStatus,
  output logic [DATA_W-1:0] busRdata,
  output logic [CMD_W-1:0]  bpCmd
);

  localparam int TOP = DATA_W - 1;

  logic              lockQ;
  logic [DATA_W-1:0] coreQ;
  logic [CMD_W-1:0]  cmdQ;
  logic [DATA_W-1:0] wrBits;
  logic [DATA_W-1:0] rdBits;

  // Register bit n travels on bus line TOP-n in both directions.
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign wrBits[i]       = busWdata[TOP-i];
    assign busRdata[TOP-i] = rdBits[i];
  end

  // Lock: clear wins over a coincident set.
  always_ff @(posedge clk) begin
    if (rst)                  lockQ <= 1'b0;
    else if (strobes.lockClr) lockQ <= 1'b0;
    else if (strobes.lockSet) lockQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 coreQ <= '0;
    else if (strobes.coreWr) coreQ <= wrBits;
  end

  always_ff @(posedge clk) begin
    if (rst)                cmdQ <= '0;
    else if (strobes.cmdWr) cmdQ <= wrBits[CMD_W-1:0];
  end

  assign bpCmd = cmdQ;

  always_comb begin
    rdBits = '0;
    if (strobes.rdLock) rdBits[0] = lockQ;
    if (strobes.rdCore) rdBits = coreQ;
    if (strobes.rdStat) rdBits[STAT_W-1:0] = bpStatus;
    if (strobes.rdCmd)  rdBits[CMD_W-1:0] = cmdQ;
  end

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!lockQ && coreQ == '0 && cmdQ == '0));

  a_r2_set_after_read: assert property (@(posedge clk) disable iff (rst)
    (strobes.lockSet && !strobes.lockClr) |=> lockQ);

  a_r3_stays_set: assert property (@(posedge clk) disable iff (rst)
    (lockQ && !strobes.lockClr) |=> lockQ);

  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    strobes.lockClr |=> !lockQ);

  a_r6_core_holds: assert property (@(posedge clk) disable iff (rst)
    !strobes.coreWr |=> $stable(coreQ));

  a_r8_cmd_holds: assert property (@(posedge clk) disable iff (rst)
    !strobes.cmdWr |=> $stable(bpCmd));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(strobes.rdLock || strobes.rdCore || strobes.rdStat || strobes.rdCmd) |-> busRdata == '0);

endmodule

// File: rtl/hwlock_regs.sv
module hwlock_regs
  import hwlock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int STAT_W = 3,
  parameter int CMD_W  = 2,
  parameter logic [ADDR_W-1:0] LOCK_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] CORE_OFS = 8'h74,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h3C,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [STAT_W-1:0] bpStatus,
  output logic [CMD_W-1:0]  bpCmd
);

  hwlockStrobes_t strobes;

  hwlock_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LOCK_OFS(LOCK_OFS), .CORE_OFS(CORE_OFS),
    .STAT_OFS(STAT_OFS), .CMD_OFS(CMD_OFS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .busSel(busSel), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .strobes(strobes)
  );

  hwlock_dp #(
    .DATA_W(DATA_W), .STAT_W(STAT_W), .CMD_W(CMD_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .busWdata(busWdata),
    .bpStatus(bpStatus), .busRdata(busRdata), .bpCmd(bpCmd)
  );

endmodule

// File: tb/sim_hwlock_regs.sv
module sim_hwlock_regs;

  localparam logic [7:0] LOCK = 8'h70, CORE = 8'h74, STAT = 8'h3C, CMDR = 8'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [2:0]  bpStatus = '0;
  logic [1:0]  bpCmd;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  bit        mLock, mPrevRd;
  bit [15:0] mCore;
  bit [1:0]  mCmd;

  always #5 clk = ~clk;

  hwlock_regs u0 (
    .clk(clk), .rst(rst), .busSel(busSel), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .bpStatus(bpStatus), .bpCmd(bpCmd)
  );

  function automatic bit [15:0] rev16(bit [15:0] v);
    bit [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic bit [15:0] expRd();
    if (!(busSel && busRd)) return 16'h0;
    case (busAddr)
      LOCK:    return {mLock, 15'h0};
      CORE:    return mCore;   // written lines read back on the same lines
      STAT:    return {bpStatus[0], bpStatus[1], bpStatus[2], 13'h0};
      CMDR:    return {mCmd[0], mCmd[1], 14'h0};
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tagOf(logic [7:0] a);
    case (a)
      LOCK:    return "R2/R3";
      CORE:    return "R6";
      STAT:    return "R7";
      CMDR:    return "R8";
      default: return "R9";
    endcase
  endfunction

  // Reference model update on each edge
  always @(posedge clk) begin
    bit rdNow, wrEn, setEv;
    rdNow = busSel && busRd && busAddr == LOCK;
    wrEn  = busSel && busWr;
    setEv = mPrevRd && !rdNow;
    if (rst) begin
      mLock = 0; mCore = 0; mCmd = 0; mPrevRd = 0;
    end else begin
      if (wrEn && busAddr == LOCK && busWdata == 16'h0) mLock = 0;
      else if (setEv) mLock = 1;
      if (wrEn && busAddr == CORE) mCore = busWdata;
      if (wrEn && busAddr == CMDR) mCmd = {busWdata[14], busWdata[15]};
      mPrevRd = rdNow;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (busRdata !== expRd()) begin
        errors++;
        $display("FAIL %s rdata addr=%h actual=%h expected=%h", tagOf(busAddr), busAddr, busRdata, expRd());
      end
      checks++;
      if (bpCmd !== mCmd) begin
        errors++;
        $display("FAIL R8 bpCmd actual=%b expected=%b", bpCmd, mCmd);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk); #1;
  endtask

  task automatic busRead(logic [7:0] a, int cyc, logic sel, output logic [15:0] d);
    busSel = sel; busAddr = a; busRd = 1'b1;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (i == 0) d = busRdata;
    end
    #1; busSel = 1'b0; busRd = 1'b0;
    idle();
  endtask

  task automatic busWrite(logic [7:0] a, logic [15:0] v, logic sel);
    busSel = sel; busAddr = a; busWr = 1'b1; busWdata = v;
    @(negedge clk); #1;
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    #1; rst = 1'b0;
    idle();
    // R1: outputs and core register cleared
    chk("R1 cmd after reset", {14'h0, bpCmd}, 16'h0);
    busRead(CORE, 1, 1'b1, d);
    chk("R1 core after reset", d, 16'h0);
    // R2: first lock read returns 0 over a three-clock strobe, then sets
    busRead(LOCK, 3, 1'b1, d);
    chk("R2 first lock read", d, 16'h0000);
    busRead(LOCK, 1, 1'b1, d);
    chk("R3 second lock read", d, 16'h8000);
    busRead(LOCK, 2, 1'b1, d);
    chk("R3 third lock read", d, 16'h8000);
    // R5: nonzero writes do not clear
    busWrite(LOCK, 16'h0001, 1'b1);
    busRead(LOCK, 1, 1'b1, d);
    chk("R5 after 0x0001 write", d, 16'h8000);
    busWrite(LOCK, 16'h8000, 1'b1);
    busRead(LOCK, 1, 1'b1, d);
    chk("R5 after 0x8000 write", d, 16'h8000);
    // R10: unselected zero write does not clear
    busWrite(LOCK, 16'h0000, 1'b0);
    busRead(LOCK, 1, 1'b1, d);
    chk("R10 unselected clear", d, 16'h8000);
    // R4: zero write clears
    busWrite(LOCK, 16'h0000, 1'b1);
    busRead(LOCK, 1, 1'b1, d);
    chk("R4 after clear", d, 16'h0000);
    busRead(LOCK, 1, 1'b1, d);
    chk("R4 re-set after read", d, 16'h8000);
    busWrite(LOCK, 16'h0000, 1'b1);
    // R4: clear coinciding with end of a lock read wins
    busSel = 1'b1; busAddr = LOCK; busRd = 1'b1;
    @(negedge clk);
    chk("R2 strobe data", busRdata, 16'h0000);
    #1; busRd = 1'b0; busWr = 1'b1; busWdata = 16'h0;
    @(negedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
    idle();
    busRead(LOCK, 1, 1'b1, d);
    chk("R4 clear wins over set", d, 16'h0000);
    busWrite(LOCK, 16'h0000, 1'b1);
    // R9: unselected read neither returns data nor sets
    busRead(LOCK, 2, 1'b0, d);
    chk("R9 unselected read data", d, 16'h0000);
    busRead(LOCK, 1, 1'b1, d);
    chk("R9 unselected read no set", d, 16'h0000);
    // R6: core semaphore accessible with lock held
    busWrite(CORE, 16'h1234, 1'b1);
    busRead(CORE, 1, 1'b1, d);
    chk("R6 core 0x1234", d, 16'h1234);
    busWrite(CORE, 16'hFFFF, 1'b1);
    busRead(CORE, 1, 1'b1, d);
    chk("R6 core 0xFFFF", d, 16'hFFFF);
    busWrite(CORE, 16'h5A5A, 1'b0);
    busRead(CORE, 1, 1'b1, d);
    chk("R10 core unselected write", d, 16'hFFFF);
    // R7: status
    bpStatus = 3'b001;
    busRead(STAT, 1, 1'b1, d);
    chk("R7 status 001", d, 16'h8000);
    bpStatus = 3'b110;
    busRead(STAT, 1, 1'b1, d);
    chk("R7 status 110", d, 16'h6000);
    busWrite(STAT, 16'hFFFF, 1'b1);
    busRead(STAT, 1, 1'b1, d);
    chk("R7 status write ignored", d, 16'h6000);
    chk("R7 write left cmd", {14'h0, bpCmd}, 16'h0);
    // R8: command
    busWrite(CMDR, 16'h8000, 1'b1);
    chk("R8 cmd bit0", {14'h0, bpCmd}, 16'h1);
    busWrite(CMDR, 16'h4000, 1'b1);
    chk("R8 cmd bit1", {14'h0, bpCmd}, 16'h2);
    busWrite(CMDR, 16'hFFFF, 1'b1);
    busRead(CMDR, 1, 1'b1, d);
    chk("R8 cmd readback", d, 16'hC000);
    // R9: sweep of undecoded offsets, lock currently set
    busRead(LOCK, 1, 1'b1, d);
    for (int a = 0; a < 256; a++) begin
      if (a != LOCK && a != CORE && a != STAT && a != CMDR) begin
        busRead(a[7:0], 1, 1'b1, d);
        chk("R9 undecoded read", d, 16'h0000);
      end
    end
    busRead(LOCK, 1, 1'b1, d);
    chk("R9 lock unchanged after sweep", d, 16'h8000);
    // R1: reset mid-run clears everything
    @(negedge clk); #1; rst = 1'b1;
    @(negedge clk); #1; rst = 1'b0;
    idle();
    chk("R1 cmd cleared", {14'h0, bpCmd}, 16'h0);
    busRead(LOCK, 1, 1'b1, d);
    chk("R1 lock cleared", d, 16'h0000);
    busRead(CORE, 1, 1'b1, d);
    chk("R1 core cleared", d, 16'h0000);
    repeat (3) idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule